// File: doc/BRIEF.md
# Serial Carry-Save Resolver

This block takes a number held in carry-save form, as two WIDTH-bit vectors, and turns it into ordinary binary one bit per clock. A single full adder and one carry flop do the work. Both vectors sit in right-shifting registers. The adder always sees their two least significant bits and the stored carry, so the true sum bit for the current position is on `sum_bit` combinationally, in the same cycle. The consumer takes that bit and pulses `shift_en`, which moves both registers one place and stores the carry-out for the next position. Serialising the operand this way adds no cycles to the consumer's iteration.

The block has two uses, picked by `conv_en` when it is loaded:
- As the per-bit source for a bit-serial modular multiplier. The multiplier reads `sum_bit` once per iteration and `result` stays zero.
- As the final carry-propagate adder. Each accepted sum bit also enters the top of a WIDTH-bit result register, so after WIDTH shifts `result` holds the binary sum modulo 2^WIDTH.

A three-state controller sequences the work, with the states ST_IDLE, ST_RUN and ST_DONE:
- Reset leaves it in ST_IDLE.
- `load` moves it from any state to ST_RUN. This is the start or restart transition.
- In ST_RUN, a `shift_en` that completes the WIDTH-th shift moves it to ST_DONE. This is the finish transition.
- ST_DONE holds until the next `load`. This is the park transition.

Top module: `serial_csa_adder`

## Requirements
- R1: When `load` is high at a clock edge, both operands are captured, the carry flop, the shift counter and `result` clear to zero, `done` goes low and the controller enters ST_RUN. `load` takes priority over `shift_en` in the same cycle.
- R2: While in ST_RUN (`bit_valid` high), `sum_bit` equals the XOR of the two operand LSBs and the stored carry, with no register delay. For the i-th accepted shift (i counted from 0) this is bit i of `op_a + op_b`.
- R3: Each accepted shift moves both operand registers right by one place with zero fill, and registers the full adder's carry-out as the carry-in for the next position.
- R4: In ST_RUN with `shift_en` low, the operands, carry and `sum_bit` hold unchanged (a stall).
- R5: After exactly WIDTH accepted shifts the controller enters ST_DONE, with `done` high and `bit_valid` low.
- R6: With `conv_en` high at load, each accepted sum bit enters `result` at bit WIDTH-1 while the older bits move down one place. At `done`, `result` equals `(op_a + op_b) mod 2^WIDTH`, and the carry out of the top bit is dropped.
- R7: With `conv_en` low at load, `result` stays zero for the whole operation.
- R8: In ST_IDLE and ST_DONE, `shift_en` has no effect: `result`, `done` and `bit_valid` keep their values.
- R9: After reset the controller is in ST_IDLE, with `done`, `bit_valid` and `result` all zero.
- R10: A `load` during ST_RUN abandons the current operation and restarts it with the new operands and a cleared carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Capture the operands and start an operation |
| conv_en | input | 1 | Sampled at load: 1 collects the result, 0 gives serial bits only |
| op_a | input | WIDTH | First carry-save vector |
| op_b | input | WIDTH | Second carry-save vector |
| shift_en | input | 1 | Consumer has taken `sum_bit`; advance one position |
| sum_bit | output | 1 | True sum bit for the current position |
| bit_valid | output | 1 | High in ST_RUN, when `sum_bit` is meaningful |
| result | output | WIDTH | Collected binary sum (conversion mode) |
| done | output | 1 | High in ST_DONE |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- All ones plus one, where the carry ripples through every position and then falls off the top. A design that cleared or dropped the carry would show ones in the serial stream. One that kept the top carry would corrupt `result`.
- All ones plus all ones.
- Stalled shifts. A design that updated the carry or the operands without `shift_en` would repeat or skip a bit.
- An operation abandoned mid-way while the carry is set, then reloaded with zeros while `shift_en` is held. A stale carry or a lost load priority would show up as a one in the new stream.
- Shifts after `done` and before the first load, and `result` in pass-through mode. A design that did not gate these would move `result` away from its expected value.

// File: rtl/sca_pkg.sv
package sca_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sca_state_e;
endpackage

// File: rtl/sca_operand_reg.sv
module sca_operand_reg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end else if (shift) begin
            q <= {1'b0, q[WIDTH-1:1]};
        end
    end

    // R1
    load_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> q == $past(d));

    // R4
    op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(q));

    // R3
    op_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && shift) |=> q[WIDTH-1] == 1'b0);
endmodule

// File: rtl/sca_bit_adder.sv
module sca_bit_adder (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic shift,
    input  logic a_bit,
    input  logic b_bit,
    output logic sum_bit,
    output logic carry_q
);
    logic carry_d;

    always_comb begin
        sum_bit = a_bit ^ b_bit ^ carry_q;
        carry_d = (a_bit & b_bit) | (a_bit & carry_q) | (b_bit & carry_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q <= 1'b0;
        end else if (load) begin
            carry_q <= 1'b0;
        end else if (shift) begin
            carry_q <= carry_d;
        end
    end

    // R1
    carry_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> carry_q == 1'b0);

    // R4
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !shift) |=> $stable(carry_q));

    // R3
    carry_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && shift && a_bit && b_bit) |=> carry_q);
endmodule

// File: rtl/sca_ctrl.sv
module sca_ctrl
    import sca_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic       shift_en,
    output sca_state_e state,
    output logic       advance,
    output logic       bit_valid,
    output logic       done
);
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    sca_state_e       state_nx;
    logic [CNT_W-1:0] cnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (load) state_nx = ST_RUN;
            ST_RUN: begin
                if (load) begin
                    state_nx = ST_RUN;
                end else if (shift_en && cnt == LAST) begin
                    state_nx = ST_DONE;
                end
            end
            ST_DONE: if (load) state_nx = ST_RUN;
            default: state_nx = ST_IDLE;
        endcase
    end

    // position counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= '0;
        end else if (advance) begin
            cnt <= cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        advance   = 1'b0;
        bit_valid = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_RUN: begin
                bit_valid = 1'b1;
                advance   = shift_en && !load;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_RUN |-> cnt <= LAST);

    // R5
    done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state) == ST_RUN && $past(shift_en));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);

    // R1
    load_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state == ST_RUN);
endmodule

// File: rtl/serial_csa_adder.sv
module serial_csa_adder
    import sca_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             conv_en,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             shift_en,
    output logic             sum_bit,
    output logic             bit_valid,
    output logic [WIDTH-1:0] result,
    output logic             done
);
    sca_state_e       state;
    logic             advance;
    logic             mode_q;
    logic             carry_q;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;

    sca_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .shift_en  (shift_en),
        .state     (state),
        .advance   (advance),
        .bit_valid (bit_valid),
        .done      (done)
    );

    sca_operand_reg #(.WIDTH(WIDTH)) u_reg_a (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (advance),
        .d     (op_a),
        .q     (a_q)
    );

    sca_operand_reg #(.WIDTH(WIDTH)) u_reg_b (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (advance),
        .d     (op_b),
        .q     (b_q)
    );

    sca_bit_adder u_fa (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .shift   (advance),
        .a_bit   (a_q[0]),
        .b_bit   (b_q[0]),
        .sum_bit (sum_bit),
        .carry_q (carry_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            result <= '0;
        end else if (load) begin
            mode_q <= conv_en;
            result <= '0;
        end else if (advance && mode_q) begin
            result <= {sum_bit, result[WIDTH-1:1]};
        end
    end

    // R7
    pass_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_q |-> result == '0);

    // R8
    result_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(result));

    // R6
    result_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && mode_q && !load) |=> result[WIDTH-1] == $past(sum_bit));

    // R2
    valid_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> !done);
endmodule

// File: tb/serial_csa_adder_test.sv
`timescale 1ns/1ps
module serial_csa_adder_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load = 1'b0;
    logic         conv_en = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         shift_en = 1'b0;
    logic         sum_bit;
    logic         bit_valid;
    logic [W-1:0] result;
    logic         done;

    int total = 0;
    int bad = 0;
    logic exp_q[$];

    always #2 clk = ~clk;

    serial_csa_adder #(.WIDTH(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .conv_en   (conv_en),
        .op_a      (op_a),
        .op_b      (op_b),
        .shift_en  (shift_en),
        .sum_bit   (sum_bit),
        .bit_valid (bit_valid),
        .result    (result),
        .done      (done)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // monitor: compares serial bits against the scoreboard queue
    always @(negedge clk) begin
        #1;
        if (rst_n && bit_valid && !load) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected bit", W'(sum_bit), W'(1'bx));
            end else if (shift_en) begin
                // R2 R3: bit consumed by this shift
                check("R2", W'(sum_bit), W'(exp_q.pop_front()));
            end else begin
                // R4: stalled bit holds
                check("R4", W'(sum_bit), W'(exp_q[0]));
            end
        end
    end

    // driver: loads an operation, pushes expected bits, issues shifts
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic conv,
                          input int stall_every, input int stop_after);
        logic [W-1:0] sum;
        int sent;
        int cyc;
        sum = a + b;
        @(negedge clk);
        load = 1'b1;
        op_a = a;
        op_b = b;
        conv_en = conv;
        shift_en = 1'b1;
        exp_q.delete();
        for (int i = 0; i < W; i++) exp_q.push_back(sum[i]);
        @(negedge clk);
        load = 1'b0;
        shift_en = 1'b0;
        #1;
        // R1 R10
        check("R1 bit_valid", W'(bit_valid), W'(1));
        check("R1 done", W'(done), W'(0));
        check("R1 result", result, '0);
        sent = 0;
        cyc = 0;
        while (sent < W && sent != stop_after) begin
            @(negedge clk);
            cyc++;
            if (stall_every != 0 && (cyc % stall_every) == 0) begin
                shift_en = 1'b0;
            end else begin
                shift_en = 1'b1;
                sent++;
            end
        end
        if (sent != W) return;
        @(negedge clk);
        shift_en = 1'b0;
        #1;
        // R5
        check("R5 done", W'(done), W'(1));
        check("R5 bit_valid", W'(bit_valid), W'(0));
        check("R5 bits left", W'(exp_q.size()), '0);
        // R6 R7
        check(conv ? "R6 result" : "R7 result", result, conv ? sum : '0);
        // R8: shifts after done are ignored
        @(negedge clk);
        shift_en = 1'b1;
        repeat (3) @(negedge clk);
        shift_en = 1'b0;
        #1;
        check("R8 result", result, conv ? sum : '0);
        check("R8 done", W'(done), W'(1));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check("watchdog", W'(0), W'(1));
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9
        check("R9 done", W'(done), W'(0));
        check("R9 bit_valid", W'(bit_valid), W'(0));
        check("R9 result", result, '0);
        // R8: shift in idle ignored
        @(negedge clk);
        shift_en = 1'b1;
        repeat (2) @(negedge clk);
        shift_en = 1'b0;
        #1;
        check("R8 idle result", result, '0);
        check("R8 idle valid", W'(bit_valid), W'(0));

        run_op('1, W'(1), 1'b1, 0, -1);          // full ripple, top carry dropped (R6)
        run_op('1, '1, 1'b1, 0, -1);             // all ones twice
        run_op('0, '0, 1'b1, 0, -1);             // zeros
        run_op(32'h8F3A_51C7, 32'h70C5_AE39, 1'b1, 3, -1);  // stalls (R4)
        run_op(32'h1234_5678, 32'hFEDC_BA98, 1'b0, 2, -1);  // pass-through (R7)
        // R10: abandon with carry set, reload zeros with shift_en held at load
        run_op('1, W'(1), 1'b1, 0, 5);
        run_op('0, '0, 1'b1, 0, -1);
        for (int n = 0; n < 4; n++) begin
            run_op(W'($urandom), W'($urandom), 1'b1, n + 2, -1);
        end
        finish_run();
    end
endmodule